// File: doc/BRIEF.md
# Return-from-interrupt state restore

This block carries out the state restore of a return from an interrupt handler. On a start strobe it takes three 64-bit inputs. The first is the machine state word that is live now. The second is the status word that was saved when the interrupt was taken. The third is the return address that was saved at the same time. From these it builds the machine state word that execution resumes with, and the instruction address to fetch next. Both results are registered. Each carries a valid flag that is high for exactly one cycle after the strobe.

Bits are numbered from the most significant end: bit 0 is vector index 63 and bit 63 is vector index 0. Most bits of the restored word are copied straight from the saved status word. A few are kept from the live word: those that hold interrupt cause information in the saved word, and one bit that belongs to a privilege level this block does not handle. Two fields follow special rules. Three enable bits are forced high whenever the saved word returns to the unprivileged problem state. The three-bit transactional-state field refuses one illegal transition. The return address is rounded down to a 4-byte boundary.

Top module: `rfi_restore_top`

## Requirements
- R1: While reset is held, and after it is released until the first start, `state_o` and `next_pc_o` are all zeros and both valid flags are low.
- R2: A start sampled high at a rising clock edge makes `state_vld_o` and `next_pc_vld_o` high together for the following cycle only. With no start at an edge, both flags are low after that edge.
- R3: Restored bits 0 to 28, 32, 37 to 41, 49, 50, 52 to 57 and 60 to 63 (MSB-first; bit n is index 63-n) equal the same bits of the saved status word. This includes bit 3.
- R4: Restored bits 33 to 36, 42 to 47 and 51 equal the same bits of the live state word.
- R5: Restored bits 29 to 31 keep the live word's value when the live word holds 0b010 there and the saved word holds 0b000 there. In every other case they take the saved word's value.
- R6: Restored bits 48, 58 and 59 each equal the saved word's own bit ORed with saved bit 49.
- R7: `next_pc_o` equals the saved return address with its two least significant bits (indices 1 and 0) forced to zero.
- R8: Without a start, changes on the data inputs have no effect: `state_o` and `next_pc_o` keep the values from the last operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a return operation; inputs are sampled at this edge |
| cur_state_i | input | 64 | Live machine state word |
| saved_status_i | input | 64 | Status word saved when the interrupt was taken |
| saved_pc_i | input | 64 | Return address saved when the interrupt was taken |
| state_o | output | 64 | Restored machine state word |
| state_vld_o | output | 1 | `state_o` is valid for this cycle |
| next_pc_o | output | 64 | Next instruction address |
| next_pc_vld_o | output | 1 | `next_pc_o` is valid for this cycle |

## Verification
Each result lies one register behind the strobe. Data and start are set up in the low phase before edge k, and the restored word, the address and both flags appear after edge k. The bench drives at falling edges and reads back at the next falling edge, half a period after the updating edge. It reads once more one cycle later, to see that the flags have dropped and that the data holds. Expected words come from a bench model that sorts each MSB-first bit number into its rule and assembles the result bit by bit.

// File: rtl/rfi_pkg.sv
package rfi_pkg;

  localparam int unsigned STATE_W = 64;

  // Convert an MSB-first bit number into a vector index.
  function automatic int unsigned bidx(input int unsigned n);
    return STATE_W - 1 - n;
  endfunction

  // Mask of MSB-first bits lo..hi inclusive.
  function automatic logic [STATE_W-1:0] span(input int unsigned lo,
                                              input int unsigned hi);
    logic [STATE_W-1:0] m;
    m = '0;
    for (int unsigned n = lo; n <= hi; n++) m[bidx(n)] = 1'b1;
    return m;
  endfunction

  // Bits restored verbatim from the saved status word.
  function automatic logic [STATE_W-1:0] copy_mask();
    return span(0, 28) | span(32, 32) | span(37, 41) | span(49, 50) |
           span(52, 57) | span(60, 63);
  endfunction

  // Bits retained from the live state word.
  function automatic logic [STATE_W-1:0] keep_mask();
    return span(33, 36) | span(42, 47) | span(51, 51);
  endfunction

  // Enable bits that the problem-state bit forces high.
  function automatic logic [STATE_W-1:0] force_mask();
    return span(48, 48) | span(58, 59);
  endfunction

  localparam int unsigned PROB_BIT = 49;
  localparam int unsigned TS_LO    = 29;
  localparam int unsigned TS_HI    = 31;
  localparam logic [2:0]  TS_GUARD_CUR   = 3'b010;
  localparam logic [2:0]  TS_GUARD_SAVED = 3'b000;

  // Decide whether the transactional field keeps the live value.
  function automatic logic ts_hold(input logic [2:0] cur_ts,
                                   input logic [2:0] sv_ts);
    return (cur_ts == TS_GUARD_CUR) && (sv_ts == TS_GUARD_SAVED);
  endfunction

endpackage

// File: rtl/rfi_state_merge.sv
module rfi_state_merge
  import rfi_pkg::*;
(
  input  logic [STATE_W-1:0] cur_i,
  input  logic [STATE_W-1:0] saved_i,
  output logic [STATE_W-1:0] merged_o,
  output logic               ts_hold_o,
  output logic               prob_force_o
);
  localparam logic [STATE_W-1:0] CPY = copy_mask();
  localparam logic [STATE_W-1:0] KEP = keep_mask();
  localparam logic [STATE_W-1:0] FRC = force_mask();
  localparam int unsigned TS_MSB_IDX = bidx(TS_LO);
  localparam int unsigned TS_LSB_IDX = bidx(TS_HI);

  logic [2:0]         cur_ts, sv_ts, ts_sel;
  logic [STATE_W-1:0] ts_part, frc_part;

  always_comb begin
    cur_ts       = cur_i[TS_MSB_IDX:TS_LSB_IDX];
    sv_ts        = saved_i[TS_MSB_IDX:TS_LSB_IDX];
    ts_hold_o    = ts_hold(cur_ts, sv_ts);
    ts_sel       = ts_hold_o ? cur_ts : sv_ts;
    prob_force_o = saved_i[bidx(PROB_BIT)];
    ts_part      = '0;
    ts_part[TS_MSB_IDX:TS_LSB_IDX] = ts_sel;
    frc_part     = (saved_i | {STATE_W{prob_force_o}}) & FRC;
    merged_o     = (saved_i & CPY) | (cur_i & KEP) | ts_part | frc_part;
  end
endmodule

// File: rtl/rfi_pc_align.sv
module rfi_pc_align #(
  parameter int unsigned PC_W       = 64,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] pc_o
);
  localparam logic [PC_W-1:0] LOW_MASK = (PC_W'(1) << ALIGN_BITS) - PC_W'(1);

  generate
    if (ALIGN_BITS == 0) begin : g_pass
      assign pc_o = pc_i;
    end else begin : g_clear
      assign pc_o = pc_i & ~LOW_MASK;
    end
  endgenerate
endmodule

// File: rtl/rfi_out_stage.sv
module rfi_out_stage #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         vld_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_o   <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= load_i;
      if (load_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/rfi_restore_top.sv
module rfi_restore_top
  import rfi_pkg::*;
#(
  parameter int unsigned PC_W       = 64,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [STATE_W-1:0] cur_state_i,
  input  logic [STATE_W-1:0] saved_status_i,
  input  logic [PC_W-1:0]    saved_pc_i,
  output logic [STATE_W-1:0] state_o,
  output logic               state_vld_o,
  output logic [PC_W-1:0]    next_pc_o,
  output logic               next_pc_vld_o
);
  logic [STATE_W-1:0] merged_w;
  logic [PC_W-1:0]    pc_aligned_w;
  logic               ts_hold_w;
  logic               prob_force_w;

  rfi_state_merge u_merge (
    .cur_i        (cur_state_i),
    .saved_i      (saved_status_i),
    .merged_o     (merged_w),
    .ts_hold_o    (ts_hold_w),
    .prob_force_o (prob_force_w)
  );

  rfi_pc_align #(.PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS)) u_align (
    .pc_i (saved_pc_i),
    .pc_o (pc_aligned_w)
  );

  rfi_out_stage #(.W(STATE_W)) u_state_q (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_i),
    .d_i    (merged_w),
    .q_o    (state_o),
    .vld_o  (state_vld_o)
  );

  rfi_out_stage #(.W(PC_W)) u_pc_q (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_i),
    .d_i    (pc_aligned_w),
    .q_o    (next_pc_o),
    .vld_o  (next_pc_vld_o)
  );

  // R2
  valid_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (state_vld_o && next_pc_vld_o));
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (!state_vld_o && !next_pc_vld_o));
  // R8
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(state_o) && $stable(next_pc_o)));
  // R3
  bit3_from_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (state_o[bidx(3)] == $past(saved_status_i[bidx(3)])));
  // R6
  prob_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && prob_force_w) |=>
      (state_o[bidx(48)] && state_o[bidx(58)] && state_o[bidx(59)]));
  // R5
  ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ts_hold_w) |=>
      (state_o[bidx(TS_LO):bidx(TS_HI)] == 3'b010));
  // R4
  keep_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (state_o[bidx(33):bidx(36)] == $past(cur_state_i[bidx(33):bidx(36)])));

  generate
    if (ALIGN_BITS > 0) begin : g_align_chk
      // R7
      pc_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        next_pc_vld_o |-> (next_pc_o[ALIGN_BITS-1:0] == '0));
      // R7
      pc_high_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (next_pc_o[PC_W-1:ALIGN_BITS] == $past(saved_pc_i[PC_W-1:ALIGN_BITS])));
    end
  endgenerate
endmodule

// File: tb/rfi_restore_top_tb.sv
module rfi_restore_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] cur_state_i = '0;
  logic [63:0] saved_status_i = '0;
  logic [63:0] saved_pc_i = '0;
  logic [63:0] state_o;
  logic        state_vld_o;
  logic [63:0] next_pc_o;
  logic        next_pc_vld_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfi_restore_top dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .cur_state_i(cur_state_i), .saved_status_i(saved_status_i),
    .saved_pc_i(saved_pc_i), .state_o(state_o), .state_vld_o(state_vld_o),
    .next_pc_o(next_pc_o), .next_pc_vld_o(next_pc_vld_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench model: classify each MSB-first bit number.
  function automatic logic [63:0] model(input logic [63:0] c, input logic [63:0] s);
    logic [63:0] r;
    logic prob, keep_ts;
    prob = s[63-49];
    keep_ts = ({c[63-29], c[63-30], c[63-31]} == 3'b010) &&
              ({s[63-29], s[63-30], s[63-31]} == 3'b000);
    for (int n = 0; n < 64; n++) begin
      if ((n >= 33 && n <= 36) || (n >= 42 && n <= 47) || n == 51)
        r[63-n] = c[63-n];
      else if (n >= 29 && n <= 31)
        r[63-n] = keep_ts ? c[63-n] : s[63-n];
      else if (n == 48 || n == 58 || n == 59)
        r[63-n] = s[63-n] | prob;
      else
        r[63-n] = s[63-n];
    end
    return r;
  endfunction

  // Run one operation and check results one cycle after the strobe.
  task automatic run_op(input string req, input logic [63:0] c,
                        input logic [63:0] s, input logic [63:0] pc);
    @(negedge clk);
    cur_state_i = c; saved_status_i = s; saved_pc_i = pc; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk({req, " R2 valid"}, {62'd0, state_vld_o, next_pc_vld_o}, 64'd3);
    chk(req, state_o, model(c, s));
    chk({req, " R7 pc"}, next_pc_o, {pc[63:2], 2'b00});
    @(negedge clk);
    chk({req, " R2 drop"}, {62'd0, state_vld_o, next_pc_vld_o}, 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 state", state_o, '0);
    chk("R1 pc", next_pc_o, '0);
    chk("R1 valid", {62'd0, state_vld_o, next_pc_vld_o}, 64'd0);
  endtask

  task automatic t_copy;
    // Problem bit clear, transactional guard not met: R3 and R4 visible.
    run_op("R3 R4 pattern a", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'h0);
    run_op("R3 R4 pattern b", 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_BFFF, 64'h1234);
    run_op("R3 R4 pattern c", 64'hA5A5_5A5A_0F0F_F0F0, 64'h5A5A_A5A5_F0F0_0F0F, 64'hDEAD_BEEF_0000_1003);
    // Bit 3 alone from the saved word.
    run_op("R3 bit3", 64'h0, 64'h1000_0000_0000_0000, 64'h8);
  endtask

  task automatic t_ts;
    logic [63:0] c, s;
    c = 64'h0; c[63-30] = 1'b1;          // live field 010
    s = 64'h0;                           // saved field 000
    run_op("R5 keep", c, s, 64'h40);
    chk("R5 field kept", {61'd0, state_o[34:32]}, 64'd2);
    s[63-31] = 1'b1;                     // saved field 001
    run_op("R5 take a", c, s, 64'h44);
    chk("R5 field taken", {61'd0, state_o[34:32]}, 64'd1);
    c = 64'h0; c[63-29] = 1'b1; c[63-30] = 1'b1; // live 110
    run_op("R5 take b", c, 64'h0, 64'h48);
    chk("R5 field zero", {61'd0, state_o[34:32]}, 64'd0);
  endtask

  task automatic t_prob;
    logic [63:0] s;
    s = 64'h0; s[63-49] = 1'b1;
    run_op("R6 forced", 64'h0, s, 64'h100);
    chk("R6 bits", {61'd0, state_o[63-48], state_o[63-58], state_o[63-59]}, 64'd7);
    s = 64'h0; s[63-58] = 1'b1;
    run_op("R6 own bit", 64'hFFFF_FFFF_FFFF_FFFF, s, 64'h104);
    chk("R6 bits own", {61'd0, state_o[63-48], state_o[63-58], state_o[63-59]}, 64'd2);
  endtask

  task automatic t_align;
    run_op("R7 low11", 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R7 low10", 64'h0, 64'h0, 64'h8000_0000_0000_0002);
  endtask

  task automatic t_hold;
    logic [63:0] st, pc;
    run_op("R8 setup", 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'h9999_AAAA_BBBB_CCCF);
    st = state_o; pc = next_pc_o;
    @(negedge clk);
    cur_state_i = ~cur_state_i; saved_status_i = ~saved_status_i; saved_pc_i = ~saved_pc_i;
    @(negedge clk);
    @(negedge clk);
    chk("R8 state held", state_o, st);
    chk("R8 pc held", next_pc_o, pc);
    chk("R8 no valid", {62'd0, state_vld_o, next_pc_vld_o}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_copy;
    t_ts;
    t_prob;
    t_align;
    t_hold;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R2 actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule